// File: doc/BRIEF.md
# PLL Parameter Programming Sequencer

This block is a hardware sequencer that reprograms one PLL out of a small set with a new multiplier, divider and post-divider. A single start pulse carries the PLL index, a 26-bit parameter word and a 32-bit extended word. The sequencer then runs the whole bring-up sequence on its own. First it writes the parameter register with the PLL held in power-down and reset, and then it writes the extended register. It waits a fixed settle time counted in clock cycles, rewrites the parameter register with power-down and reset released, and finally watches the lock flag of the selected PLL.

The block reports the outcome with single-cycle pulses. A done pulse follows a lock. An error pulse follows an index that names no PLL, and the same error pulse follows a lock that fails to arrive within a cycle budget. The sequencer drives the register strobes and data itself. It reads only two things from the surroundings: the upper six bits of each parameter register, which it keeps unchanged, and the per-PLL lock flags, which are bit 31 of the extended registers.

A separate combinational helper converts a set of parameter fields and an input frequency into the nominal output frequency.

Top module: `pll_prog_seq`

## Requirements
- R1: Parameter word layout: M in bits [12:0], N in [18:13], P in [22:19], power-off in bit 23, bypass in bit 24, reset in bit 25. The first write after an accepted start puts M, N and P unchanged into [22:0], sets bits 25 and 23 to 1, and drives bits [31:26] from `cur_hi_i` of the selected PLL.
- R2: In the cycle right after the first write, the extended word is written to the same PLL's extended register.
- R3: The release write comes exactly CYC_PER_US*SETTLE_US+2 cycles after the first write. This leaves a settle interval of CYC_PER_US*SETTLE_US cycles after the extended write.
- R4: The release write carries the same M, N and P and the same bits [31:26], with bits 25, 24 and 23 all 0.
- R5: When lock_i of the selected PLL is 1 during the wait, done_o pulses for exactly one cycle, one cycle later. busy_o is 0 in that same cycle.
- R6: If the lock flag does not appear within TIMEOUT_CYC cycles after the release write, err_o pulses once, TIMEOUT_CYC+1 cycles after that write. No done pulse follows and the block returns to idle. A lock that first shows in the last cycle of the budget still counts as a lock.
- R7: A start with an index of NUM_PLL or above gives an err_o pulse in the next cycle. It drives no strobe and never raises busy_o.
- R8: A start that arrives while busy_o is 1 is ignored. The running sequence finishes unchanged and no second sequence follows.
- R9: Only the strobes of the selected PLL are driven, and at most one strobe is high in any cycle.
- R10: rate_o equals rate_in_i when rate_byp_i is 1. Otherwise it equals floor(rate_in_i*(M+1)/((N+1)*(P+1))).
- R11: During and right after reset, busy_o, done_o, err_o and all strobes are 0.
- R12: Bits 23, 24 and 25 of param_i have no effect. Bypass is 0 in both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse |
| pll_idx_i | input | IDX_W | Index of the PLL to program |
| param_i | input | 26 | New parameter word |
| ext_i | input | 32 | New extended parameter word |
| cur_hi_i | input | NUM_PLL x 6 | Current bits [31:26] of each parameter register |
| lock_i | input | NUM_PLL | Lock flag of each PLL (extended register bit 31) |
| wr_en_o | output | NUM_PLL | Parameter register write strobes |
| ext_wr_en_o | output | NUM_PLL | Extended register write strobes |
| wr_data_o | output | 32 | Write data shared by all strobes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after lock |
| err_o | output | 1 | One-cycle pulse on bad index or lock timeout |
| rate_m_i | input | 13 | Helper: multiplier field M |
| rate_n_i | input | 6 | Helper: divider field N |
| rate_p_i | input | 4 | Helper: post-divider field P |
| rate_byp_i | input | 1 | Helper: bypass flag |
| rate_in_i | input | RATE_IN_W | Helper: input frequency |
| rate_o | output | RATE_IN_W+14 | Helper: nominal output frequency |

## Verification
The hardest cases to reach are at the edge of the lock window. A lock must arrive exactly in the last cycle of the budget and count as success, and a lock one cycle later must end in a timeout. The bench includes a lock model that raises the selected PLL's flag a programmable number of cycles after it sees the release write. It runs delays of 1, 3, TIMEOUT_CYC and TIMEOUT_CYC+1, and one case where the flag never rises. A second hard case is a start that arrives in the middle of the settle wait, with a different index and word. The bench checks that the register traffic stays exactly as scored for the first sequence and that busy_o falls afterwards.

// File: rtl/pll_seq_pkg.sv
`timescale 1ns/1ps
package pll_seq_pkg;
  localparam int PW    = 26;
  localparam int REG_W = 32;
  localparam int HI_W  = REG_W - PW;
  localparam int M_W   = 13;
  localparam int N_W   = 6;
  localparam int P_W   = 4;

  // M/N/P live in bits [22:0]; control bits are forced by the sequencer
  localparam logic [PW-1:0] FIELD_MASK = 26'h07F_FFFF;
  // reset (25) and power-off (23) asserted during load, bypass (24) low
  localparam logic [PW-1:0] HOLD_BITS  = 26'h280_0000;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_LOAD   = 3'd1,
    S_EXT    = 3'd2,
    S_SETTLE = 3'd3,
    S_REL    = 3'd4,
    S_LOCK   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/pll_seq_timer.sv
`timescale 1ns/1ps
module pll_seq_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | dec_i;
  assign cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pll_seq_ctrl.sv
`timescale 1ns/1ps
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int NUM_PLL     = 4,
  parameter int IDX_W       = 3,
  parameter int SEL_W       = 2,
  parameter int CNT_W       = 15,
  parameter int SETTLE_CYC  = 20000,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic [PW-1:0]                 param_i,
  input  logic [REG_W-1:0]              ext_i,
  input  logic [NUM_PLL-1:0][HI_W-1:0]  cur_hi_i,
  input  logic [NUM_PLL-1:0]            lock_i,
  output logic [NUM_PLL-1:0]            wr_en_o,
  output logic [NUM_PLL-1:0]            ext_wr_en_o,
  output logic [REG_W-1:0]              wr_data_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  output logic                          tmr_load_o,
  output logic [CNT_W-1:0]              tmr_val_o,
  output logic                          tmr_dec_o,
  input  logic                          tmr_zero_i
);
  seq_state_e       state_q, state_d;
  logic [SEL_W-1:0] sel_q;
  logic [PW-1:0]    param_q;
  logic [REG_W-1:0] ext_q;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             cap;
  logic             idx_ok;
  logic             par_wr, ext_wr;
  logic [PW-1:0]    low_word;

  assign idx_ok = ({1'b0, idx_i} < (IDX_W+1)'(NUM_PLL));

  // next-state process
  always_comb begin
    state_d    = state_q;
    cap        = 1'b0;
    done_d     = 1'b0;
    err_d      = 1'b0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    tmr_dec_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (idx_ok) begin
            cap     = 1'b1;
            state_d = S_LOAD;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      S_LOAD: state_d = S_EXT;
      S_EXT: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(SETTLE_CYC - 1);
        state_d    = S_SETTLE;
      end
      S_SETTLE: begin
        if (tmr_zero_i) state_d = S_REL;
        else            tmr_dec_o = 1'b1;
      end
      S_REL: begin
        tmr_load_o = 1'b1;
        tmr_val_o  = CNT_W'(TIMEOUT_CYC - 1);
        state_d    = S_LOCK;
      end
      S_LOCK: begin
        if (lock_i[sel_q]) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (tmr_zero_i) begin
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          tmr_dec_o = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      param_q <= '0;
      ext_q   <= '0;
    end else if (cap) begin
      sel_q   <= idx_i[SEL_W-1:0];
      param_q <= param_i;
      ext_q   <= ext_i;
    end
  end

  assign par_wr   = (state_q == S_LOAD) || (state_q == S_REL);
  assign ext_wr   = (state_q == S_EXT);
  assign low_word = (param_q & FIELD_MASK) | ((state_q == S_LOAD) ? HOLD_BITS : '0);
  assign wr_data_o = ext_wr ? ext_q : {cur_hi_i[sel_q], low_word};

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_strobe
    assign wr_en_o[g]     = par_wr && (sel_q == SEL_W'(g));
    assign ext_wr_en_o[g] = ext_wr && (sel_q == SEL_W'(g));
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/pll_rate_calc.sv
`timescale 1ns/1ps
module pll_rate_calc
  import pll_seq_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 46
) (
  input  logic [M_W-1:0]  m_i,
  input  logic [N_W-1:0]  n_i,
  input  logic [P_W-1:0]  p_i,
  input  logic            byp_i,
  input  logic [IN_W-1:0] in_i,
  output logic [OUT_W-1:0] rate_o
);
  localparam int DEN_W = N_W + P_W + 2;

  logic [M_W:0]       m_inc;
  logic [N_W:0]       n_inc;
  logic [P_W:0]       p_inc;
  logic [DEN_W-1:0]   den;
  logic [OUT_W-1:0]   prod;

  assign m_inc  = {1'b0, m_i} + (M_W+1)'(1);
  assign n_inc  = {1'b0, n_i} + (N_W+1)'(1);
  assign p_inc  = {1'b0, p_i} + (P_W+1)'(1);
  assign den    = DEN_W'(n_inc) * DEN_W'(p_inc);
  assign prod   = OUT_W'(in_i) * OUT_W'(m_inc);
  assign rate_o = byp_i ? OUT_W'(in_i) : (prod / OUT_W'(den));
endmodule

// File: rtl/pll_prog_seq.sv
`timescale 1ns/1ps
module pll_prog_seq
  import pll_seq_pkg::*;
#(
  parameter int NUM_PLL     = 4,
  parameter int IDX_W       = 3,
  parameter int CYC_PER_US  = 200,
  parameter int SETTLE_US   = 100,
  parameter int TIMEOUT_CYC = 4096,
  parameter int RATE_IN_W   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [IDX_W-1:0]              pll_idx_i,
  input  logic [25:0]                   param_i,
  input  logic [31:0]                   ext_i,
  input  logic [NUM_PLL-1:0][5:0]       cur_hi_i,
  input  logic [NUM_PLL-1:0]            lock_i,
  output logic [NUM_PLL-1:0]            wr_en_o,
  output logic [NUM_PLL-1:0]            ext_wr_en_o,
  output logic [31:0]                   wr_data_o,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          err_o,
  input  logic [12:0]                   rate_m_i,
  input  logic [5:0]                    rate_n_i,
  input  logic [3:0]                    rate_p_i,
  input  logic                          rate_byp_i,
  input  logic [RATE_IN_W-1:0]          rate_in_i,
  output logic [RATE_IN_W+13:0]         rate_o
);
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int MAX_CYC    = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);
  localparam int SEL_W      = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;
  localparam int RATE_OUT_W = RATE_IN_W + M_W + 1;

  logic             rst_meta_n, rst_sync_n;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  pll_seq_ctrl #(
    .NUM_PLL     (NUM_PLL),
    .IDX_W       (IDX_W),
    .SEL_W       (SEL_W),
    .CNT_W       (CNT_W),
    .SETTLE_CYC  (SETTLE_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .idx_i       (pll_idx_i),
    .param_i     (param_i),
    .ext_i       (ext_i),
    .cur_hi_i    (cur_hi_i),
    .lock_i      (lock_i),
    .wr_en_o     (wr_en_o),
    .ext_wr_en_o (ext_wr_en_o),
    .wr_data_o   (wr_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .tmr_dec_o   (tmr_dec),
    .tmr_zero_i  (tmr_zero)
  );

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  pll_rate_calc #(.IN_W(RATE_IN_W), .OUT_W(RATE_OUT_W)) u_rate (
    .m_i    (rate_m_i),
    .n_i    (rate_n_i),
    .p_i    (rate_p_i),
    .byp_i  (rate_byp_i),
    .in_i   (rate_in_i),
    .rate_o (rate_o)
  );
endmodule

// File: rtl/pll_prog_seq_chk.sv
`timescale 1ns/1ps
module pll_prog_seq_chk #(
  parameter int NUM_PLL = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_PLL-1:0] wr_en_o,
  input logic [NUM_PLL-1:0] ext_wr_en_o,
  input logic [2:0]         wr_ctl,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o
);
  // wr_ctl = {reset, bypass, power-off} of the write data

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en_o, ext_wr_en_o}));

  a_r2_ext_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) && wr_ctl[0]) |=> (ext_wr_en_o == $past(wr_en_o)));

  a_r4_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) && !wr_ctl[2]) |-> (wr_ctl[1:0] == 2'b00));

  a_r12_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en_o) |-> !wr_ctl[1]);

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r6_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o));

  a_r11_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_en_o) || (|ext_wr_en_o)) |-> busy_o);
endmodule

bind pll_prog_seq pll_prog_seq_chk #(.NUM_PLL(NUM_PLL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en_o     (wr_en_o),
  .ext_wr_en_o (ext_wr_en_o),
  .wr_ctl      (wr_data_o[25:23]),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/pll_prog_seq_tb_top.sv
`timescale 1ns/1ps
module pll_prog_seq_tb_top;
  localparam int NP  = 4;
  localparam int CPU = 4;
  localparam int SUS = 5;
  localparam int S   = CPU * SUS;
  localparam int TO  = 40;

  typedef struct packed {
    logic [1:0]  kind;   // 0 param write, 1 ext write, 2 done, 3 err
    logic [1:0]  idx;
    logic [31:0] data;
  } ev_t;

  logic             clk, rst_n, start;
  logic [2:0]       idx_in;
  logic [25:0]      prm;
  logic [31:0]      ext;
  logic [NP-1:0][5:0] cur_hi;
  logic [NP-1:0]    lock_v;
  logic [NP-1:0]    wr_en_o, ext_wr_en_o;
  logic [31:0]      wr_data_o;
  logic             busy_o, done_o, err_o;
  logic [12:0]      r_m;
  logic [5:0]       r_n;
  logic [3:0]       r_p;
  logic             r_byp;
  logic [31:0]      r_in;
  logic [45:0]      rate_o;

  int   n_chk = 0, n_bad = 0;
  ev_t  exp_q[$];
  int   cyc = 0, t_load = 0, t_ext = 0, t_rel = 0, t_end = 0;
  int   lock_dly = 0, lock_cnt = 0, lock_tgt = 0;
  bit   busy_seen = 0;

  pll_prog_seq #(
    .NUM_PLL(NP), .IDX_W(3), .CYC_PER_US(CPU), .SETTLE_US(SUS),
    .TIMEOUT_CYC(TO), .RATE_IN_W(32)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pll_idx_i(idx_in),
    .param_i(prm), .ext_i(ext), .cur_hi_i(cur_hi), .lock_i(lock_v),
    .wr_en_o(wr_en_o), .ext_wr_en_o(ext_wr_en_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .rate_m_i(r_m), .rate_n_i(r_n), .rate_p_i(r_p), .rate_byp_i(r_byp),
    .rate_in_i(r_in), .rate_o(rate_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic take_ev(logic [1:0] kind, logic [1:0] idx, logic [31:0] data);
    ev_t got, want;
    string tag;
    got = '{kind: kind, idx: idx, data: data};
    if (exp_q.size() == 0) begin
      check(1'b0, "R9 unexpected event", 64'(got), 64'(0));
    end else begin
      want = exp_q.pop_front();
      case (want.kind)
        2'd0:    tag = want.data[23] ? "R1 load write" : "R4 release write";
        2'd1:    tag = "R2 ext write";
        2'd2:    tag = "R5 done";
        default: tag = "R6 or R7 error";
      endcase
      check(got == want, tag, 64'(got), 64'(want));
    end
  endtask

  // monitor: compares outputs against the scoreboard queue, models lock
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit armed;
      armed = 0;
      if (busy_o) busy_seen = 1;
      for (int g = 0; g < NP; g++) begin
        if (wr_en_o[g]) begin
          take_ev(2'd0, 2'(g), wr_data_o);
          if (wr_data_o[23]) begin
            t_load = cyc;
            lock_v[g] = 1'b0;
          end else begin
            t_rel = cyc;
            if (lock_dly > 0) begin
              lock_cnt = lock_dly;
              lock_tgt = g;
              armed = 1;
            end
          end
        end
        if (ext_wr_en_o[g]) begin
          take_ev(2'd1, 2'(g), wr_data_o);
          t_ext = cyc;
        end
      end
      if (done_o) begin take_ev(2'd2, 2'd0, 32'd0); t_end = cyc; end
      if (err_o)  begin take_ev(2'd3, 2'd0, 32'd0); t_end = cyc; end
      if (!armed && lock_cnt > 0) begin
        lock_cnt--;
        if (lock_cnt == 0) lock_v[lock_tgt] = 1'b1;
      end
    end
  end

  task automatic wait_idle();
    do begin
      @(negedge clk); #1;
    end while (busy_o || exp_q.size() != 0);
  endtask

  // driver: pushes expected items, then launches a sequence
  task automatic run_seq(int idx, logic [25:0] p, logic [31:0] e, int dly,
                         bit locks, bit intrude);
    logic [31:0] w_load, w_rel;
    w_load = {cur_hi[idx], 3'b101, p[22:0]};
    w_rel  = {cur_hi[idx], 3'b000, p[22:0]};
    exp_q.push_back('{kind: 2'd0, idx: 2'(idx), data: w_load});
    exp_q.push_back('{kind: 2'd1, idx: 2'(idx), data: e});
    exp_q.push_back('{kind: 2'd0, idx: 2'(idx), data: w_rel});
    exp_q.push_back('{kind: locks ? 2'd2 : 2'd3, idx: 2'd0, data: 32'd0});
    lock_dly = dly;
    @(negedge clk); #1;
    start = 1'b1; idx_in = 3'(idx); prm = p; ext = e;
    @(negedge clk); #1;
    start = 1'b0;
    if (intrude) begin
      repeat (6) @(negedge clk);
      #1;
      check(busy_o == 1'b1, "R8 busy before intruding start", 64'(busy_o), 64'd1);
      start = 1'b1; idx_in = 3'((idx + 1) % NP); prm = 26'h155_AAAA; ext = 32'hDEAD_0001;
      @(negedge clk); #1;
      start = 1'b0;
    end
    wait_idle();
    check(t_ext - t_load == 1, "R2 ext write spacing", 64'(t_ext - t_load), 64'd1);
    check(t_rel - t_load == S + 2, "R3 settle interval", 64'(t_rel - t_load), 64'(S + 2));
    if (locks)
      check(t_end - t_rel == dly + 1, "R5 done timing", 64'(t_end - t_rel), 64'(dly + 1));
    else
      check(t_end - t_rel == TO + 1, "R6 timeout timing", 64'(t_end - t_rel), 64'(TO + 1));
    @(negedge clk); #1;
    check(!done_o && !err_o, "R5 single-cycle pulse", 64'({done_o, err_o}), 64'd0);
    if (intrude) begin
      repeat (4) @(negedge clk);
      #1;
      check(!busy_o && exp_q.size() == 0, "R8 no second sequence", 64'(busy_o), 64'd0);
    end
  endtask

  task automatic bad_idx(int idx);
    exp_q.push_back('{kind: 2'd3, idx: 2'd0, data: 32'd0});
    busy_seen = 0;
    @(negedge clk); #1;
    start = 1'b1; idx_in = 3'(idx);
    @(negedge clk); #1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy_seen && exp_q.size() == 0, "R7 invalid index", 64'(busy_seen), 64'd0);
  endtask

  task automatic rate_chk(logic [12:0] m, logic [5:0] n, logic [3:0] p, bit byp,
                          logic [31:0] fin);
    longint unsigned expv;
    r_m = m; r_n = n; r_p = p; r_byp = byp; r_in = fin;
    #1;
    if (byp) expv = fin;
    else     expv = ((longint'(fin) * (longint'(m) + 1)) / (longint'(n) + 1)) / (longint'(p) + 1);
    check(rate_o == 46'(expv), "R10 rate helper", 64'(rate_o), 64'(expv));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; idx_in = '0; prm = '0; ext = '0; lock_v = '0;
    cur_hi[0] = 6'h00; cur_hi[1] = 6'h3F; cur_hi[2] = 6'h2A; cur_hi[3] = 6'h15;
    r_m = '0; r_n = '0; r_p = '0; r_byp = 1'b0; r_in = '0;
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o && !done_o && !err_o && wr_en_o == '0 && ext_wr_en_o == '0,
          "R11 outputs in reset", 64'({busy_o, done_o, err_o, wr_en_o, ext_wr_en_o}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(!busy_o && !done_o && !err_o && wr_en_o == '0 && ext_wr_en_o == '0,
          "R11 outputs after reset", 64'({busy_o, done_o, err_o, wr_en_o, ext_wr_en_o}), 64'd0);

    // M=95 N=2 P=1 on PLL 0, lock after 3 cycles
    run_seq(0, {3'b000, 4'd1, 6'd2, 13'd95}, 32'h0000_0031, 3, 1'b1, 1'b0);
    // R12: control bits set in the supplied word, PLL 3, lock after 1 cycle
    run_seq(3, {3'b111, 4'd15, 6'd0, 13'd127}, 32'h0000_003F, 1, 1'b1, 1'b0);
    // lock in the very last cycle of the budget still counts (R6 boundary)
    run_seq(2, {3'b010, 4'd9, 6'd4, 13'd667}, 32'h0000_014D, TO, 1'b1, 1'b0);
    // no lock at all: timeout on PLL 1
    run_seq(1, {3'b000, 4'd0, 6'd2, 13'd119}, 32'h0000_003D, 0, 1'b0, 1'b0);
    // lock one cycle too late: timeout
    run_seq(1, {3'b001, 4'd15, 6'd2, 13'd95}, 32'h1234_5678, TO + 1, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    // invalid indices
    bad_idx(4);
    bad_idx(7);
    // start while busy is ignored
    run_seq(2, {3'b000, 4'd3, 6'd5, 13'd1000}, 32'hCAFE_0002, 2, 1'b1, 1'b1);

    rate_chk(13'd95,  6'd2, 4'd1,  1'b0, 32'd25_000_000);
    rate_chk(13'd127, 6'd0, 4'd15, 1'b0, 32'd25_000_000);
    rate_chk(13'd667, 6'd4, 4'd9,  1'b0, 32'd25_000_000);
    rate_chk(13'h1FFF, 6'd0, 4'd0, 1'b0, 32'hFFFF_FFFF);
    rate_chk(13'd100, 6'd63, 4'd15, 1'b0, 32'd7);
    rate_chk(13'd119, 6'd2, 4'd0,  1'b1, 32'd25_000_000);

    check(exp_q.size() == 0, "R9 scoreboard drained", 64'(exp_q.size()), 64'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule